// File: doc/BRIEF.md
# Ethernet Preamble Stripper and Frame Delimiter

This block sits directly behind a PHY-side receive interface that delivers one byte per accepted cycle, with a per-byte valid flag and a frame-active flag. It hunts for the preamble pattern 0x55 and then waits for the start-of-frame delimiter 0xD5. The bytes after the delimiter go out on a byte stream with start and end markers. The preamble, the delimiter and everything received outside a locked frame are dropped.

The block never counts preamble bytes. A single 0x55 ahead of the delimiter is enough to lock. Some PHYs lose part of the preamble while they acquire bit sync, and this is what lets the block follow them. Any unexpected byte during the preamble makes the block return to the hunt. If the frame-active flag falls before the delimiter has been seen, the block also returns to the hunt, and in both cases nothing is produced. The block keeps each content byte in a one-byte hold stage until it knows whether that byte is the last one. This is how the final byte can carry the end marker.

Top module: `eth_sfd_deframer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, fr_vld, fr_sof and fr_eof are 0. This holds whatever is on the receive inputs.
- R2: A byte counts as accepted when rx_active=1 and rx_byte_vld=1. After one or more accepted 0x55 bytes followed by an accepted 0xD5, every later accepted byte of that frame is output unchanged, including bytes equal to 0x55 or 0xD5. Preamble and delimiter bytes are never output.
- R3: Any number of preamble bytes from 1 upward (for example 1, 7 or 20) leads to the same output.
- R4: After at least one 0x55, an accepted byte other than 0x55 or 0xD5 sends the block back to the hunt with no output. A 0xD5 that follows it in the same frame does not start a frame.
- R5: An accepted 0xD5 that has no 0x55 ahead of it is ignored, and the bytes after it produce no output.
- R6: The first output byte of a frame carries fr_sof=1. No other byte carries it.
- R7: The last accepted content byte is output with fr_eof=1. This happens one clock after the first cycle in which rx_active=0. A frame with a single content byte gives one output with both fr_sof=1 and fr_eof=1.
- R8: If rx_active falls before any content byte has been accepted (during the preamble or just after the delimiter), nothing is output and the block hunts again.
- R9: Every content byte except the last one is output one clock after the cycle in which the next content byte is accepted. Cycles with rx_active=1 and rx_byte_vld=0 produce no output and do not end the frame.
- R10: Bytes presented while rx_active=0 are ignored, even when rx_byte_vld=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_byte | input | 8 | Received byte from the PHY side |
| rx_byte_vld | input | 1 | rx_byte holds a byte this cycle |
| rx_active | input | 1 | A frame is being received |
| fr_byte | output | 8 | Frame content byte |
| fr_vld | output | 1 | fr_byte is valid |
| fr_sof | output | 1 | First content byte of a frame |
| fr_eof | output | 1 | Last content byte of a frame |

## Verification
The hardest cases to reach are those where the end marker depends on a future event. Examples are a frame of one content byte, a frame whose last byte is followed by idle gap cycles, and a delimiter followed at once by the fall of rx_active. The driver builds each of these as a sequence of per-cycle port settings and writes the expected output cycle of every byte into the scoreboard at the moment the deciding event is driven, so the latency of the hold stage is checked exactly. Aborted preambles, delimiters with no preamble and bytes presented while inactive are followed by a window in which no output may appear.

// File: rtl/eth_dfr_pkg.sv
package eth_dfr_pkg;

    typedef enum logic [1:0] {
        HUNT_IDLE = 2'd0,
        HUNT_PRE  = 2'd1,
        HUNT_BODY = 2'd2
    } hunt_state_e;

    typedef struct packed {
        hunt_state_e state;
        logic        first;
    } hunt_regs_t;

endpackage

// File: rtl/eth_dfr_hunt.sv
module eth_dfr_hunt
    import eth_dfr_pkg::*;
#(
    parameter int              DATA_W  = 8,
    parameter logic [DATA_W-1:0] PRE_PAT = 8'h55,
    parameter logic [DATA_W-1:0] SFD_PAT = 8'hD5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_in,
    output logic              content_vld,
    output logic              content_first
);

    hunt_regs_t r_d, r_q;
    logic       accept;

    assign accept = active && byte_vld;

    always_comb begin
        r_d = r_q;
        if (!active) begin
            r_d.state = HUNT_IDLE;
            r_d.first = 1'b0;
        end else if (byte_vld) begin
            unique case (r_q.state)
                HUNT_IDLE: begin
                    if (byte_in == PRE_PAT) r_d.state = HUNT_PRE;
                end
                HUNT_PRE: begin
                    if (byte_in == SFD_PAT) begin
                        r_d.state = HUNT_BODY;
                        r_d.first = 1'b1;
                    end else if (byte_in != PRE_PAT) begin
                        r_d.state = HUNT_IDLE;
                    end
                end
                HUNT_BODY: begin
                    r_d.first = 1'b0;
                end
                default: begin
                    r_d.state = HUNT_IDLE;
                    r_d.first = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: HUNT_IDLE, first: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign content_vld   = accept && (r_q.state == HUNT_BODY);
    assign content_first = r_q.first;

    AST_DROP_RESETS_HUNT: assert property (@(posedge clk) disable iff (rst)
        !active |=> (r_q.state == HUNT_IDLE)); // R8

    AST_BODY_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == HUNT_BODY && $past(r_q.state) != HUNT_BODY)
        |-> $past(accept && byte_in == SFD_PAT && r_q.state == HUNT_PRE)); // R2

    AST_IDLE_SFD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == HUNT_IDLE && accept && byte_in == SFD_PAT)
        |=> (r_q.state == HUNT_IDLE)); // R5

    AST_BAD_PRE_ABORTS: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == HUNT_PRE && accept && byte_in != PRE_PAT && byte_in != SFD_PAT)
        |=> (r_q.state == HUNT_IDLE)); // R4

endmodule

// File: rtl/eth_dfr_hold.sv
module eth_dfr_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              content_vld,
    input  logic              content_first,
    input  logic [DATA_W-1:0] content_byte,
    output logic [DATA_W-1:0] out_byte,
    output logic              out_vld,
    output logic              out_sof,
    output logic              out_eof
);

    typedef struct packed {
        logic              held;
        logic [DATA_W-1:0] held_byte;
        logic              held_sof;
        logic              o_vld;
        logic [DATA_W-1:0] o_byte;
        logic              o_sof;
        logic              o_eof;
    } hold_regs_t;

    hold_regs_t h_d, h_q;

    always_comb begin
        h_d       = h_q;
        h_d.o_vld = 1'b0;
        h_d.o_sof = 1'b0;
        h_d.o_eof = 1'b0;
        if (!active) begin
            if (h_q.held) begin
                h_d.o_vld  = 1'b1;
                h_d.o_byte = h_q.held_byte;
                h_d.o_sof  = h_q.held_sof;
                h_d.o_eof  = 1'b1;
            end
            h_d.held     = 1'b0;
            h_d.held_sof = 1'b0;
        end else if (content_vld) begin
            if (h_q.held) begin
                h_d.o_vld  = 1'b1;
                h_d.o_byte = h_q.held_byte;
                h_d.o_sof  = h_q.held_sof;
            end
            h_d.held      = 1'b1;
            h_d.held_byte = content_byte;
            h_d.held_sof  = content_first;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign out_byte = h_q.o_byte;
    assign out_vld  = h_q.o_vld;
    assign out_sof  = h_q.o_sof;
    assign out_eof  = h_q.o_eof;

    AST_EMIT_FROM_HOLD: assert property (@(posedge clk) disable iff (rst)
        h_q.o_vld |-> $past(h_q.held)); // R9

    AST_EOF_AFTER_DROP: assert property (@(posedge clk) disable iff (rst)
        h_q.o_eof |-> (h_q.o_vld && $past(!active))); // R7

    AST_MID_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
        (h_q.o_vld && !h_q.o_eof) |-> $past(content_vld)); // R9

endmodule

// File: rtl/eth_sfd_deframer.sv
module eth_sfd_deframer #(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] PRE_PAT = 8'h55,
    parameter logic [DATA_W-1:0] SFD_PAT = 8'hD5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_byte_vld,
    input  logic              rx_active,
    output logic [DATA_W-1:0] fr_byte,
    output logic              fr_vld,
    output logic              fr_sof,
    output logic              fr_eof
);

    logic content_vld;
    logic content_first;

    eth_dfr_hunt #(
        .DATA_W  (DATA_W),
        .PRE_PAT (PRE_PAT),
        .SFD_PAT (SFD_PAT)
    ) u_hunt (
        .clk           (clk),
        .rst           (rst),
        .active        (rx_active),
        .byte_vld      (rx_byte_vld),
        .byte_in       (rx_byte),
        .content_vld   (content_vld),
        .content_first (content_first)
    );

    eth_dfr_hold #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk           (clk),
        .rst           (rst),
        .active        (rx_active),
        .content_vld   (content_vld),
        .content_first (content_first),
        .content_byte  (rx_byte),
        .out_byte      (fr_byte),
        .out_vld       (fr_vld),
        .out_sof       (fr_sof),
        .out_eof       (fr_eof)
    );

    // Frame-open tracker used only by the checks below.
    logic open_d, open_q;

    always_comb begin
        open_d = open_q;
        if (fr_vld) open_d = !fr_eof;
    end

    always_ff @(posedge clk) begin
        if (rst) open_q <= 1'b0;
        else     open_q <= open_d;
    end

    AST_SOF_OPENS_FRAME: assert property (@(posedge clk) disable iff (rst)
        (fr_vld && fr_sof) |-> !open_q); // R6

    AST_BODY_INSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
        (fr_vld && !fr_sof) |-> open_q); // R6

    AST_MARKERS_NEED_VALID: assert property (@(posedge clk) disable iff (rst)
        (fr_sof || fr_eof) |-> fr_vld); // R7

endmodule

// File: tb/eth_sfd_deframer_tb.sv
module eth_sfd_deframer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_byte_vld = 1'b0;
    logic       rx_active = 1'b0;
    logic [7:0] fr_byte;
    logic       fr_vld, fr_sof, fr_eof;

    always #2.5 clk = ~clk;

    eth_sfd_deframer u_dut (
        .clk         (clk),
        .rst         (rst),
        .rx_byte     (rx_byte),
        .rx_byte_vld (rx_byte_vld),
        .rx_active   (rx_active),
        .fr_byte     (fr_byte),
        .fr_vld      (fr_vld),
        .fr_sof      (fr_sof),
        .fr_eof      (fr_eof)
    );

    typedef struct {
        logic [7:0] b;
        logic       sof;
        logic       eof;
        int         cyc;
        string      tag;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    int   out_cnt = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops the scoreboard whenever the design produces a byte.
    always @(negedge clk) begin
        if (!rst && fr_vld) begin
            out_cnt = out_cnt + 1;
            checks  = checks + 1;
            if (q.size() == 0) begin
                failures = failures + 1;
                $display("FAIL R2/R4/R5/R8/R10 unexpected output: got byte=%02h sof=%0b eof=%0b, expected none",
                         fr_byte, fr_sof, fr_eof);
            end else begin
                e = q.pop_front();
                if (fr_byte !== e.b || fr_sof !== e.sof || fr_eof !== e.eof || cyc != e.cyc) begin
                    failures = failures + 1;
                    $display("FAIL %s: got byte=%02h sof=%0b eof=%0b cyc=%0d, expected byte=%02h sof=%0b eof=%0b cyc=%0d",
                             e.tag, fr_byte, fr_sof, fr_eof, cyc, e.b, e.sof, e.eof, e.cyc);
                end
            end
        end
    end

    task automatic drive(input logic a, input logic v, input logic [7:0] b);
        rx_active   = a;
        rx_byte_vld = v;
        rx_byte     = b;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] byte_of(input int seed, input int k);
        if (seed == 99) return (k % 2 == 0) ? 8'h55 : 8'hD5;
        return 8'((seed * 7 + k * 29 + 3) & 255);
    endfunction

    task automatic push(input logic [7:0] b, input logic s, input logic f, input int c, input string tag);
        exp_t it;
        it.b = b; it.sof = s; it.eof = f; it.cyc = c; it.tag = tag;
        q.push_back(it);
    endtask

    // Driver: sends preamble, delimiter and content; predicts each output byte and cycle.
    task automatic send_frame(input int npre, input int nbytes, input int seed,
                              input int gap, input string tag);
        logic [7:0] prev;
        logic [7:0] cur;
        prev = 8'h00;
        for (int i = 0; i < npre; i++) drive(1'b1, 1'b1, 8'h55);
        drive(1'b1, 1'b1, 8'hD5);
        for (int k = 0; k < nbytes; k++) begin
            if (gap > 0 && k > 0 && (k % gap) == 0) begin
                drive(1'b1, 1'b0, 8'hD5);
                drive(1'b1, 1'b0, 8'h55);
            end
            cur = byte_of(seed, k);
            if (k > 0) push(prev, (k == 1), 1'b0, cyc + 1, tag);
            drive(1'b1, 1'b1, cur);
            prev = cur;
        end
        push(prev, (nbytes == 1), 1'b1, cyc + 1, tag);
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 8'h00);
    endtask

    task automatic check_silence(input int mark, input string tag);
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 8'h00);
        checks = checks + 1;
        if (out_cnt != mark) begin
            failures = failures + 1;
            $display("FAIL %s: got %0d output bytes, expected 0", tag, out_cnt - mark);
        end
    endtask

    task automatic check_drained(input string tag);
        drive(1'b0, 1'b0, 8'h00);
        checks = checks + 1;
        if (q.size() != 0) begin
            failures = failures + 1;
            $display("FAIL %s: got %0d bytes still missing, expected 0", tag, q.size());
        end
    endtask

    initial begin
        int mark;
        // R1: reset holds outputs quiet while the inputs carry a frame-like pattern
        rx_active = 1'b1; rx_byte_vld = 1'b1; rx_byte = 8'h55;
        repeat (2) @(posedge clk);
        rx_byte = 8'hD5;
        repeat (2) @(posedge clk);
        rx_byte = 8'h3C;
        @(negedge clk);
        checks = checks + 1;
        if (fr_vld !== 1'b0 || fr_sof !== 1'b0 || fr_eof !== 1'b0) begin
            failures = failures + 1;
            $display("FAIL R1 during reset: got vld=%0b sof=%0b eof=%0b, expected 0 0 0", fr_vld, fr_sof, fr_eof);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        rx_active = 1'b0; rx_byte_vld = 1'b0;
        @(posedge clk);
        @(negedge clk);
        checks = checks + 1;
        if (fr_vld !== 1'b0 || fr_sof !== 1'b0 || fr_eof !== 1'b0) begin
            failures = failures + 1;
            $display("FAIL R1 after reset: got vld=%0b sof=%0b eof=%0b, expected 0 0 0", fr_vld, fr_sof, fr_eof);
        end
        @(posedge clk); #1;

        send_frame(7, 5, 1, 0, "R2 standard preamble");
        check_drained("R2 standard preamble drained");
        send_frame(1, 3, 2, 0, "R3 one preamble byte");
        send_frame(20, 4, 3, 0, "R3 long preamble");
        send_frame(2, 1, 4, 0, "R6 R7 single content byte");
        send_frame(3, 6, 99, 0, "R2 pattern bytes in content");
        send_frame(4, 7, 5, 2, "R9 gaps inside frame");
        check_drained("R9 R7 all bytes delivered");

        // R4: bad byte in preamble, then a delimiter, in the same frame
        mark = out_cnt;
        drive(1'b1, 1'b1, 8'h55);
        drive(1'b1, 1'b1, 8'h55);
        drive(1'b1, 1'b1, 8'hA7);
        drive(1'b1, 1'b1, 8'hD5);
        drive(1'b1, 1'b1, 8'h11);
        drive(1'b1, 1'b1, 8'h22);
        check_silence(mark, "R4 aborted preamble");

        // R5: delimiter with no preamble
        mark = out_cnt;
        drive(1'b1, 1'b1, 8'hD5);
        drive(1'b1, 1'b1, 8'h33);
        drive(1'b1, 1'b1, 8'h44);
        check_silence(mark, "R5 lone delimiter");

        // R8: drop during preamble, then a delimiter in a new frame
        mark = out_cnt;
        drive(1'b1, 1'b1, 8'h55);
        drive(1'b1, 1'b1, 8'h55);
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b1, 1'b1, 8'hD5);
        drive(1'b1, 1'b1, 8'h66);
        check_silence(mark, "R8 drop in preamble");

        // R8: drop right after the delimiter
        mark = out_cnt;
        drive(1'b1, 1'b1, 8'h55);
        drive(1'b1, 1'b1, 8'hD5);
        drive(1'b1, 1'b0, 8'h77);
        check_silence(mark, "R8 drop after delimiter");

        // R10: bytes while inactive
        mark = out_cnt;
        drive(1'b0, 1'b1, 8'h55);
        drive(1'b0, 1'b1, 8'h55);
        drive(1'b0, 1'b1, 8'hD5);
        drive(1'b0, 1'b1, 8'h12);
        check_silence(mark, "R10 inactive bytes");

        // Recovery after all the error cases, then back-to-back frames
        send_frame(1, 2, 6, 0, "R3 R6 recovery frame");
        send_frame(5, 3, 7, 3, "R9 back-to-back frame");
        check_drained("R7 final drain");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks   = checks + 1;
            failures = failures + 1;
            $display("FAIL watchdog: got no completion, expected finish within 20000 cycles");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule